// File: doc/BRIEF.md
# ROM Search Step Sequencer

This block carries out one branch decision of a 1-Wire ROM search. A single start pulse runs three bus slots in a fixed order. The first slot reads the bit that the devices drive for the current ROM position. The second reads the inverted copy of that bit. The third writes back the direction the search follows. The two bits read decide whether the third slot runs and what it writes. A bit-level bus master elsewhere turns each slot request into line timing. This sequencer only orders the slots and makes the branch decision.

The caller holds the preferred direction on `pref_dir` while it pulses `start`. It then waits for `done`, which lasts one cycle, and reads the 3-bit `result` and the `err` flag. Both stay unchanged until the next step completes.

Slot requests toward the bus master form a valid/ready channel. `slot_valid` rises with `slot_is_write` and `slot_wbit` set. All three hold until the master raises `slot_ready`. The request is accepted on the first clock edge where both are high. The master may hold `slot_ready` low for as many cycles as it needs. The master reports the end of an accepted slot with a one-cycle `slot_done` and, for a read, the sampled line level on `slot_rbit`. Every slot is guarded by a cycle budget that covers both the wait for acceptance and the wait for completion.

Top module: `rom_search_step`

## Requirements
- R1: A step always issues a read slot first (slot_is_write=0), then a second read slot (slot_is_write=0). A third slot, when one is issued, is a write (slot_is_write=1).
- R2: When both bits read are 1, no write slot is issued. The step completes with result 3'b011 and err=0.
- R3: When both bits read are 0, the write slot carries the preferred direction. The result is 3'b100 for direction 1 and 3'b000 for direction 0.
- R4: When exactly one bit read is 1, the write slot carries the first bit read. The result is 3'b101 when that bit is 1 and 3'b010 when it is 0.
- R5: Result layout: bit 0 holds the first bit read, bit 1 holds the second bit read, and bit 2 holds the direction written.
- R6: A slot that is still unaccepted or uncompleted after TIMEOUT_CYC active clock edges ends the step. The step then reports result 3'b011 with err=1. A step that completes normally reports err=0.
- R7: busy rises the cycle after an accepted start and falls in the cycle that done is high. A start that arrives while busy is high has no effect.
- R8: done is high for exactly one cycle per step. result and err change only in that cycle.
- R9: While slot_valid is high and slot_ready is low, slot_valid, slot_is_write and slot_wbit keep their values. slot_done counts only after the request has been accepted.
- R10: The preferred direction is sampled in the cycle start is accepted. Later changes of pref_dir during the step have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a step (taken only while idle) |
| pref_dir | input | 1 | Direction to follow when both bits read are 0 |
| busy | output | 1 | Step in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | 3 | {direction, second bit, first bit}, or 3'b011 |
| err | output | 1 | Last step ended on slot timeout |
| slot_valid | output | 1 | Slot request valid |
| slot_ready | input | 1 | Bus master accepts the request |
| slot_is_write | output | 1 | 1 = write slot, 0 = read slot |
| slot_wbit | output | 1 | Bit to send in a write slot |
| slot_done | input | 1 | Accepted slot has finished |
| slot_rbit | input | 1 | Line level sampled in a read slot |

## Verification
The bench drives all four combinations of the two bits read, each with both preferred directions. The 0/0 case is the only one where the preferred direction must reach the line. The mixed cases must ignore that input. The 1/1 case must drop the write slot entirely. Acceptance and completion latencies vary between steps. This separates a design that honours `slot_ready` and waits for `slot_done` from one that advances on a fixed schedule. Two hang patterns, one in acceptance and one in completion, show whether the cycle budget covers both waits. A second start mid-step and a preferred direction flipped after start show that only the input state at the accepted start counts.

// File: rtl/rom_search_pkg.sv
package rom_search_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RD_ID  = 2'd1,
    ST_RD_CMP = 2'd2,
    ST_WR_DIR = 2'd3
  } step_state_t;

  // bit2 = direction taken, bit1 = inverted bit, bit0 = true bit
  typedef struct packed {
    logic dir;
    logic cmp;
    logic idb;
  } step_res_t;

  localparam logic [2:0] RES_NO_DEVICE = 3'b011;

endpackage

// File: rtl/rom_search_decide.sv
module rom_search_decide (
  input  logic idb,
  input  logic cmp,
  input  logic pref,
  output logic skip,
  output logic dir
);
  // both high: nobody pulled the line low, nothing to write
  // one high: only one branch exists, follow the true bit
  // both low: devices disagree, follow the caller's preference
  always_comb begin
    skip = idb & cmp;
    if (idb ^ cmp) dir = idb;
    else           dir = pref;
  end
endmodule

// File: rtl/rom_search_slot.sv
module rom_search_slot #(
  parameter int TIMEOUT_CYC = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic launch_wr,
  input  logic launch_bit,
  output logic slot_valid,
  input  logic slot_ready,
  output logic slot_is_write,
  output logic slot_wbit,
  input  logic slot_done,
  output logic fin,
  output logic tmo
);
  logic wait_q;
  logic active;

  assign active = slot_valid | wait_q;
  assign fin    = wait_q & slot_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_valid    <= 1'b0;
      wait_q        <= 1'b0;
      slot_is_write <= 1'b0;
      slot_wbit     <= 1'b0;
    end else if (launch) begin
      slot_valid    <= 1'b1;
      wait_q        <= 1'b0;
      slot_is_write <= launch_wr;
      slot_wbit     <= launch_bit;
    end else if (fin || tmo) begin
      slot_valid <= 1'b0;
      wait_q     <= 1'b0;
    end else if (slot_valid && slot_ready) begin
      slot_valid <= 1'b0;
      wait_q     <= 1'b1;
    end
  end

  generate
    if (TIMEOUT_CYC > 0) begin : g_budget
      localparam int CW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
      localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);
      logic [CW-1:0] cnt;

      assign tmo = active & ~fin & (cnt == LAST);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   cnt <= '0;
        else if (launch || fin || tmo) cnt <= '0;
        else if (active)              cnt <= cnt + 1'b1;
      end

      assert_budget_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    end else begin : g_nobudget
      assign tmo = 1'b0;
    end
  endgenerate

  assert_hold_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
    slot_valid && !slot_ready && !tmo && !launch |=>
      slot_valid && $stable(slot_is_write) && $stable(slot_wbit));

  assert_valid_xor_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(slot_valid && wait_q));

endmodule

// File: rtl/rom_search_seq.sv
module rom_search_seq
  import rom_search_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       pref_dir,
  input  logic       fin,
  input  logic       tmo,
  input  logic       rbit,
  input  logic       skip,
  input  logic       dir,
  output logic       id_q,
  output logic       pref_q,
  output logic       launch,
  output logic       launch_wr,
  output logic       launch_bit,
  output logic       busy,
  output logic       done,
  output logic [2:0] result,
  output logic       err
);
  step_state_t state;
  logic        cmp_q, dir_q;
  logic        accept, finish_ok, finish_skip;
  step_res_t   res_full;

  assign accept      = (state == ST_IDLE) & start;
  assign finish_skip = fin & (state == ST_RD_CMP) & skip;
  assign finish_ok   = finish_skip | (fin & (state == ST_WR_DIR));
  assign launch      = accept
                     | (fin & (state == ST_RD_ID))
                     | (fin & (state == ST_RD_CMP) & ~skip);
  assign launch_wr   = (state == ST_RD_CMP);
  assign launch_bit  = dir;
  assign busy        = (state != ST_IDLE);

  assign res_full.dir = dir_q;
  assign res_full.cmp = cmp_q;
  assign res_full.idb = id_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      id_q   <= 1'b0;
      cmp_q  <= 1'b0;
      dir_q  <= 1'b0;
      pref_q <= 1'b0;
      done   <= 1'b0;
      result <= '0;
      err    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        state  <= ST_RD_ID;
        pref_q <= pref_dir;
      end else if (tmo) begin
        state  <= ST_IDLE;
        done   <= 1'b1;
        result <= RES_NO_DEVICE;
        err    <= 1'b1;
      end else if (finish_ok) begin
        state  <= ST_IDLE;
        done   <= 1'b1;
        err    <= 1'b0;
        result <= finish_skip ? RES_NO_DEVICE : res_full;
      end else if (fin) begin
        case (state)
          ST_RD_ID: begin
            id_q  <= rbit;
            state <= ST_RD_CMP;
          end
          ST_RD_CMP: begin
            cmp_q <= rbit;
            dir_q <= dir;
            state <= ST_WR_DIR;
          end
          default: state <= state;
        endcase
      end
    end
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result) && $stable(err));

  assert_busy_from_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_single_branch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err && (result[0] ^ result[1]) |-> result[2] == result[0]);

  assert_no_device_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done && result[1:0] == 2'b11 |-> result[2] == 1'b0);

  assert_no_write_skip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    finish_skip |=> state == ST_IDLE);

endmodule

// File: rtl/rom_search_step.sv
module rom_search_step #(
  parameter int TIMEOUT_CYC = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       pref_dir,
  output logic       busy,
  output logic       done,
  output logic [2:0] result,
  output logic       err,
  output logic       slot_valid,
  input  logic       slot_ready,
  output logic       slot_is_write,
  output logic       slot_wbit,
  input  logic       slot_done,
  input  logic       slot_rbit
);
  logic launch, launch_wr, launch_bit;
  logic fin, tmo;
  logic id_q, pref_q, skip, dir;

  rom_search_slot #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_slot (
    .clk           (clk),
    .rst_n         (rst_n),
    .launch        (launch),
    .launch_wr     (launch_wr),
    .launch_bit    (launch_bit),
    .slot_valid    (slot_valid),
    .slot_ready    (slot_ready),
    .slot_is_write (slot_is_write),
    .slot_wbit     (slot_wbit),
    .slot_done     (slot_done),
    .fin           (fin),
    .tmo           (tmo)
  );

  rom_search_decide u_decide (
    .idb  (id_q),
    .cmp  (slot_rbit),
    .pref (pref_q),
    .skip (skip),
    .dir  (dir)
  );

  rom_search_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .pref_dir   (pref_dir),
    .fin        (fin),
    .tmo        (tmo),
    .rbit       (slot_rbit),
    .skip       (skip),
    .dir        (dir),
    .id_q       (id_q),
    .pref_q     (pref_q),
    .launch     (launch),
    .launch_wr  (launch_wr),
    .launch_bit (launch_bit),
    .busy       (busy),
    .done       (done),
    .result     (result),
    .err        (err)
  );

  assert_write_third_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slot_valid) && slot_is_write |-> !$past(busy, 1) == 1'b0);

endmodule

// File: tb/rom_search_step_bench.sv
`timescale 1ns/1ps
module rom_search_step_bench;
  localparam int TMO = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic pref_dir = 1'b0;
  logic busy, done, err;
  logic [2:0] result;
  logic slot_valid, slot_is_write, slot_wbit;
  logic slot_ready = 1'b0;
  logic slot_done = 1'b0;
  logic slot_rbit = 1'b0;

  always #10 clk = ~clk;

  rom_search_step #(.TIMEOUT_CYC(TMO)) u_rom_search_step (
    .clk(clk), .rst_n(rst_n), .start(start), .pref_dir(pref_dir),
    .busy(busy), .done(done), .result(result), .err(err),
    .slot_valid(slot_valid), .slot_ready(slot_ready),
    .slot_is_write(slot_is_write), .slot_wbit(slot_wbit),
    .slot_done(slot_done), .slot_rbit(slot_rbit)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  bit cmp_en = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int m_st = 0;
  int m_cnt = 0;
  bit m_valid = 0, m_id = 0, m_cmp = 0, m_dir = 0, m_pref = 0;
  bit m_done = 0, m_err = 0;
  bit [2:0] m_res = 0;

  always @(posedge clk) begin : mdl
    bit comp;
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_valid = 0; m_id = 0; m_cmp = 0; m_dir = 0;
      m_pref = 0; m_done = 0; m_err = 0; m_res = 0;
    end else begin
      m_done = 0;
      if (m_st == 0) begin
        if (start) begin m_st = 1; m_valid = 1; m_cnt = 0; m_pref = pref_dir; end
      end else begin
        comp = !m_valid && slot_done;
        if (comp) begin
          m_cnt = 0;
          if (m_st == 1) begin
            m_id = slot_rbit; m_st = 2; m_valid = 1;
          end else if (m_st == 2) begin
            m_cmp = slot_rbit;
            if (m_id && slot_rbit) begin
              m_res = 3'b011; m_err = 0; m_done = 1; m_st = 0; m_valid = 0;
            end else begin
              m_dir = (m_id != slot_rbit) ? m_id : m_pref;
              m_st = 3; m_valid = 1;
            end
          end else begin
            m_res = {m_dir, m_cmp, m_id}; m_err = 0; m_done = 1; m_st = 0; m_valid = 0;
          end
        end else if (m_cnt == TMO - 1) begin
          m_res = 3'b011; m_err = 1; m_done = 1; m_st = 0; m_valid = 0;
        end else begin
          m_cnt++;
          if (m_valid && slot_ready) m_valid = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en && !finished) begin
      check(busy == (m_st != 0), "R7", "busy", busy, m_st != 0);
      check(done == m_done, "R8", "done", done, m_done);
      check(result == m_res, "R5", "result", result, m_res);
      check(err == m_err, "R6", "err", err, m_err);
      check(slot_valid == m_valid, "R9", "slot_valid", slot_valid, m_valid);
      if (m_valid) check(slot_is_write == (m_st == 3), "R1", "slot_is_write",
                         slot_is_write, m_st == 3);
      if (m_valid && m_st == 3) check(slot_wbit == m_dir, "R4", "slot_wbit",
                                      slot_wbit, m_dir);
    end
  end

  // ---------------- bus master responder ----------------
  int cfg_rl = 0, cfg_dl = 0;
  bit cfg_hr = 0, cfg_hd = 0, cfg_id = 0, cfg_cmp = 0;
  bit rsp_clear = 0;
  int ph = 0, wcnt = 0, dcnt = 0, rd_idx = 0, nwr = 0;
  bit cur_w = 0, cur_b = 0, wr_bit = 0;

  initial begin
    forever begin
      @(negedge clk);
      slot_done = 1'b0;
      if (rsp_clear) begin
        ph = 0; wcnt = 0; dcnt = 0; rd_idx = 0; nwr = 0; slot_ready = 1'b0;
        rsp_clear = 0;
      end
      if (ph == 0) begin
        if (slot_valid && !cfg_hr) begin
          if (wcnt >= cfg_rl) begin
            slot_ready = 1'b1; cur_w = slot_is_write; cur_b = slot_wbit; ph = 1;
          end else wcnt++;
        end
      end else begin
        if (ph == 1) begin
          slot_ready = 1'b0; dcnt = 0; ph = 2;
          if (cur_w) begin nwr++; wr_bit = cur_b; end
        end
        if (ph == 2 && !cfg_hd) begin
          if (dcnt >= cfg_dl) begin
            slot_done = 1'b1;
            slot_rbit = (rd_idx == 0) ? cfg_id : cfg_cmp;
            if (!cur_w) rd_idx++;
            ph = 0; wcnt = 0;
          end else dcnt++;
        end
      end
    end
  end

  // ---------------- one search step ----------------
  task automatic run_step(input bit id, input bit cb, input bit pref,
                          input int rl, input int dl, input bit hr, input bit hd,
                          input bit poke, input bit flip, input string req);
    bit [2:0] exp_res;
    bit exp_err, exp_dir;
    int exp_nwr;
    bit seen;
    bit [2:0] held;
    if (hr || hd) begin exp_res = 3'b011; exp_err = 1; exp_nwr = 0; exp_dir = 0; end
    else if (id && cb) begin exp_res = 3'b011; exp_err = 0; exp_nwr = 0; exp_dir = 0; end
    else begin
      exp_dir = (id != cb) ? id : pref;
      exp_res = {exp_dir, cb, id}; exp_err = 0; exp_nwr = 1;
    end
    @(negedge clk);
    cfg_id = id; cfg_cmp = cb; cfg_rl = rl; cfg_dl = dl; cfg_hr = hr; cfg_hd = hd;
    rsp_clear = 1;
    @(negedge clk);
    start = 1'b1; pref_dir = pref;
    @(negedge clk);
    start = 1'b0;
    if (flip) pref_dir = ~pref;
    seen = 0;
    for (int i = 0; i < 400 && !seen; i++) begin
      @(negedge clk);
      if (poke && i == 2) start = 1'b1;
      else start = 1'b0;
      if (done) seen = 1;
    end
    start = 1'b0;
    check(seen, req, "done seen", seen, 1);
    check(result == exp_res, req, "result", result, exp_res);
    check(err == exp_err, req, "err", err, exp_err);
    check(nwr == exp_nwr, req, "write slots", nwr, exp_nwr);
    if (exp_nwr == 1) check(wr_bit == exp_dir, req, "written bit", wr_bit, exp_dir);
    held = result;
    repeat (3) @(negedge clk);
    check(result == held && !busy && !done, "R8", "hold after done", result, held);
    cfg_hr = 0; cfg_hd = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !slot_valid && result == 3'b000 && !err, "R7",
          "reset state", {busy, done, slot_valid, err}, 0);
    cmp_en = 1;
    run_step(1, 1, 0, 0, 0, 0, 0, 0, 0, "R2");
    run_step(1, 1, 1, 2, 1, 0, 0, 0, 0, "R2");
    run_step(0, 0, 1, 1, 2, 0, 0, 0, 0, "R3");
    run_step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
    run_step(1, 0, 0, 2, 1, 0, 0, 0, 0, "R4");
    run_step(0, 1, 1, 0, 3, 0, 0, 0, 0, "R4");
    run_step(0, 0, 1, 0, 1, 0, 0, 0, 1, "R10");
    run_step(0, 0, 0, 1, 0, 0, 0, 0, 1, "R10");
    run_step(1, 0, 1, 1, 1, 0, 0, 1, 0, "R7");
    run_step(0, 0, 1, 0, 0, 1, 0, 0, 0, "R6");
    run_step(0, 1, 0, 0, 0, 0, 0, 0, 0, "R6");
    run_step(1, 0, 0, 0, 0, 0, 1, 0, 0, "R6");
    run_step(1, 0, 1, TMO - 3, 0, 0, 0, 0, 0, "R9");
    for (int k = 0; k < 8; k++)
      run_step(k[0], k[1], k[2], k % 3, (k + 1) % 4, 0, 0, 0, 0, "R5");
    run_step(0, 0, 1, 0, 0, 0, 0, 0, 0, "R1");
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule